// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes the accumulator value, a second operand, a five-bit operation code and the machine's current carry, and it produces an 8-bit result together with a strobe saying whether the accumulator should take that result. Result and strobe are combinational. The same evaluation produces new sign, zero, auxiliary-carry, parity and carry values. A flag byte register inside the block captures them on the rising clock edge when the flag write enable is high. Each operation updates only the flags it owns.

All add and subtract forms share one adder split at the nibble boundary. Subtraction inverts the operand and the carry-in, and the carry flag holds the borrow. Compare runs the subtract path but never asks for an accumulator write. The rotate forms either loop the end bit around or pass it through the carry. The reset input is asynchronous and active low. It is expected to be released in step with the clock by the surrounding reset logic.

Top module: `alu8_flagged`

## Requirements
- R1: Codes 0 (ADD) and 1 (ADC) give acc+opnd and acc+opnd+carry_i modulo 256. The carry flag is the carry out of bit 7. ADD ignores carry_i.
- R2: Codes 2 (SUB) and 3 (SBB) give acc-opnd and acc-opnd-carry_i modulo 256. The carry flag is set when a borrow occurs, so it reads as a borrow flag.
- R3: For adds, increment and decrement, AC is set when a carry leaves bit 3 into bit 4. For SUB, SBB and CMP, AC is the inverse of the borrow out of the low nibble.
- R4: On every flag update that includes them, S equals result bit 7, Z is set only for a zero result, and P is set when the result has an even count of ones.
- R5: Code 7 (CMP) writes all five flags exactly as SUB would and drives result_we_o low. result_o shows the difference.
- R6: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result, update S, Z and P, and clear both CY and AC.
- R7: Code 8 (CMA) returns the ones' complement of the accumulator and leaves all flags unchanged.
- R8: Codes 9 (RLC) and 10 (RRC) rotate left and right by one bit without passing through carry. The bit rotated out is copied to CY, and no other flag changes.
- R9: Codes 11 (RAL) and 12 (RAR) rotate through carry. carry_i fills the vacated bit, the bit shifted out becomes CY, and no other flag changes.
- R10: Code 13 (CMC) sets CY to the inverse of carry_i, and code 14 (STC) sets CY to 1. Both drive result_we_o low with result_o equal to the accumulator, and no other flag changes.
- R11: Codes 15 (INC) and 16 (DEC) give acc+1 and acc-1 and update S, Z, AC and P. CY keeps its value.
- R12: flags_o places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bit 1 reads 1 and bits 3 and 5 read 0. Reset clears all five flags, giving 0x02.
- R13: While flag_we_i is low, flags_o keeps its value whatever the operation.
- R14: Codes 17 to 31 drive result_we_o low, pass the accumulator to result_o and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| op_i | input | 5 | Operation code |
| carry_i | input | 1 | Current carry flag used by ADC, SBB, RAL, RAR and CMC |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Flag byte |

## Verification
On every cycle the assertions check the following:
- After any update that includes them, sign, zero and parity agree with the result that was on the port.
- The flag byte holds while writes are disabled.
- INC and DEC leave carry alone, and CMA leaves every flag alone.
- STC and CMC drive carry as required.
- Compare and the unused codes never request an accumulator write.

Only the bench's scenarios can show the other cases, because their expected values come from arithmetic worked out by hand:
- carry and borrow values, and the nibble auxiliary carry in both the add and subtract senses;
- the exact bit that each rotate moves through or around carry;
- the reset value of the flag byte.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned OP_W = 5;

  localparam logic [OP_W-1:0] OP_ADD = 5'd0;
  localparam logic [OP_W-1:0] OP_ADC = 5'd1;
  localparam logic [OP_W-1:0] OP_SUB = 5'd2;
  localparam logic [OP_W-1:0] OP_SBB = 5'd3;
  localparam logic [OP_W-1:0] OP_AND = 5'd4;
  localparam logic [OP_W-1:0] OP_OR  = 5'd5;
  localparam logic [OP_W-1:0] OP_XOR = 5'd6;
  localparam logic [OP_W-1:0] OP_CMP = 5'd7;
  localparam logic [OP_W-1:0] OP_CMA = 5'd8;
  localparam logic [OP_W-1:0] OP_RLC = 5'd9;
  localparam logic [OP_W-1:0] OP_RRC = 5'd10;
  localparam logic [OP_W-1:0] OP_RAL = 5'd11;
  localparam logic [OP_W-1:0] OP_RAR = 5'd12;
  localparam logic [OP_W-1:0] OP_CMC = 5'd13;
  localparam logic [OP_W-1:0] OP_STC = 5'd14;
  localparam logic [OP_W-1:0] OP_INC = 5'd15;
  localparam logic [OP_W-1:0] OP_DEC = 5'd16;

  // Flag byte positions (neighbouring logic decodes these)
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned FB_S    = 7;
  localparam int unsigned FB_Z    = 6;
  localparam int unsigned FB_AC   = 4;
  localparam int unsigned FB_P    = 2;
  localparam int unsigned FB_ONE  = 1;
  localparam int unsigned FB_CY   = 0;

  typedef enum logic [1:0] {
    YS_OPND, YS_NOPND, YS_ZERO, YS_ONES
  } ysel_e;

  typedef enum logic [1:0] {
    CS_ZERO, CS_ONE, CS_CIN, CS_NCIN
  } csel_e;

  typedef enum logic [3:0] {
    RS_ADD, RS_AND, RS_OR, RS_XOR, RS_CMA,
    RS_RLC, RS_RRC, RS_RAL, RS_RAR, RS_PASS
  } rsel_e;

  typedef enum logic [2:0] {
    CY_COUT, CY_NCOUT, CY_ZERO, CY_MSB, CY_LSB, CY_NCIN, CY_ONE
  } cysel_e;

  typedef struct packed {
    ysel_e  ysel;
    csel_e  csel;
    rsel_e  rsel;
    cysel_e cysel;
    logic   ac_from_add;
    logic   upd_szp;
    logic   upd_ac;
    logic   upd_cy;
    logic   wr_acc;
  } ctrl_t;

endpackage

// File: rtl/alu8_adder.sv
// Split adder: low half and high half chained, exposing the half carry.
module alu8_adder #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              half_c_o,
  output logic              cout_o
);
  localparam int unsigned LO_W = DATA_W / 2;
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, x_i[LO_W-1:0]} + {1'b0, y_i[LO_W-1:0]} + {{LO_W{1'b0}}, cin_i};
    hi_sum = {1'b0, x_i[DATA_W-1:LO_W]} + {1'b0, y_i[DATA_W-1:LO_W]}
           + {{HI_W{1'b0}}, lo_sum[LO_W]};
  end

  assign sum_o    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign half_c_o = lo_sum[LO_W];
  assign cout_o   = hi_sum[HI_W];
endmodule

// File: rtl/alu8_parity.sv
// Even-parity detector built as an XOR chain.
module alu8_parity #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] d_i,
  output logic              even_o
);
  logic [DATA_W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_chain
    assign chain[i+1] = chain[i] ^ d_i[i];
  end

  assign even_o = ~chain[DATA_W];
endmodule

// File: rtl/alu8_opdec.sv
// Maps the operation code onto datapath controls and flag update masks.
module alu8_opdec
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o             = '0;
    ctrl_o.ysel        = YS_OPND;
    ctrl_o.csel        = CS_ZERO;
    ctrl_o.rsel        = RS_PASS;
    ctrl_o.cysel       = CY_COUT;
    ctrl_o.ac_from_add = 1'b0;
    ctrl_o.upd_szp     = 1'b0;
    ctrl_o.upd_ac      = 1'b0;
    ctrl_o.upd_cy      = 1'b0;
    ctrl_o.wr_acc      = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        ctrl_o.rsel        = RS_ADD;
        ctrl_o.ac_from_add = 1'b1;
        ctrl_o.upd_szp     = 1'b1;
        ctrl_o.upd_ac      = 1'b1;
        ctrl_o.upd_cy      = 1'b1;
        ctrl_o.wr_acc      = (op_i != OP_CMP);
        if (op_i == OP_ADD || op_i == OP_ADC) begin
          ctrl_o.ysel  = YS_OPND;
          ctrl_o.cysel = CY_COUT;
          ctrl_o.csel  = (op_i == OP_ADC) ? CS_CIN : CS_ZERO;
        end else begin
          ctrl_o.ysel  = YS_NOPND;
          ctrl_o.cysel = CY_NCOUT;
          ctrl_o.csel  = (op_i == OP_SBB) ? CS_NCIN : CS_ONE;
        end
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctrl_o.rsel    = (op_i == OP_AND) ? RS_AND :
                         (op_i == OP_OR)  ? RS_OR  : RS_XOR;
        ctrl_o.cysel   = CY_ZERO;
        ctrl_o.upd_szp = 1'b1;
        ctrl_o.upd_ac  = 1'b1;
        ctrl_o.upd_cy  = 1'b1;
        ctrl_o.wr_acc  = 1'b1;
      end
      OP_CMA: begin
        ctrl_o.rsel   = RS_CMA;
        ctrl_o.wr_acc = 1'b1;
      end
      OP_RLC, OP_RAL: begin
        ctrl_o.rsel   = (op_i == OP_RLC) ? RS_RLC : RS_RAL;
        ctrl_o.cysel  = CY_MSB;
        ctrl_o.upd_cy = 1'b1;
        ctrl_o.wr_acc = 1'b1;
      end
      OP_RRC, OP_RAR: begin
        ctrl_o.rsel   = (op_i == OP_RRC) ? RS_RRC : RS_RAR;
        ctrl_o.cysel  = CY_LSB;
        ctrl_o.upd_cy = 1'b1;
        ctrl_o.wr_acc = 1'b1;
      end
      OP_CMC: begin
        ctrl_o.cysel  = CY_NCIN;
        ctrl_o.upd_cy = 1'b1;
      end
      OP_STC: begin
        ctrl_o.cysel  = CY_ONE;
        ctrl_o.upd_cy = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctrl_o.rsel        = RS_ADD;
        ctrl_o.ysel        = (op_i == OP_INC) ? YS_ZERO : YS_ONES;
        ctrl_o.csel        = (op_i == OP_INC) ? CS_ONE  : CS_ZERO;
        ctrl_o.ac_from_add = 1'b1;
        ctrl_o.upd_szp     = 1'b1;
        ctrl_o.upd_ac      = 1'b1;
        ctrl_o.wr_acc      = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
// Five status bits with per-group update enables, packed into the flag byte.
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              upd_szp_i,
  input  logic              upd_ac_i,
  input  logic              upd_cy_i,
  input  logic              s_i,
  input  logic              z_i,
  input  logic              ac_i,
  input  logic              p_i,
  input  logic              cy_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic s_q, z_q, ac_q, p_q, cy_q;
  logic s_d, z_d, ac_d, p_d, cy_d;
  logic en;

  assign en = we_i & (upd_szp_i | upd_ac_i | upd_cy_i);

  always_comb begin
    s_d  = upd_szp_i ? s_i  : s_q;
    z_d  = upd_szp_i ? z_i  : z_q;
    p_d  = upd_szp_i ? p_i  : p_q;
    ac_d = upd_ac_i  ? ac_i : ac_q;
    cy_d = upd_cy_i  ? cy_i : cy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= 1'b0;
      z_q  <= 1'b0;
      ac_q <= 1'b0;
      p_q  <= 1'b0;
      cy_q <= 1'b0;
    end else if (en) begin
      s_q  <= s_d;
      z_q  <= z_d;
      ac_q <= ac_d;
      p_q  <= p_d;
      cy_q <= cy_d;
    end
  end

  always_comb begin
    flags_o         = '0;
    flags_o[FB_S]   = s_q;
    flags_o[FB_Z]   = z_q;
    flags_o[FB_AC]  = ac_q;
    flags_o[FB_P]   = p_q;
    flags_o[FB_ONE] = 1'b1;
    flags_o[FB_CY]  = cy_q;
  end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic                carry_i,
  input  logic                flag_we_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                result_we_o,
  output logic [FLAG_W-1:0]   flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_half_c;
  logic              add_cout;
  logic [DATA_W-1:0] res;
  logic              par_even;
  logic              ac_n;
  logic              cy_n;

  alu8_opdec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  always_comb begin
    case (ctrl.ysel)
      YS_OPND:  add_y = opnd_i;
      YS_NOPND: add_y = ~opnd_i;
      YS_ZERO:  add_y = '0;
      default:  add_y = '1;
    endcase
    case (ctrl.csel)
      CS_ZERO: add_cin = 1'b0;
      CS_ONE:  add_cin = 1'b1;
      CS_CIN:  add_cin = carry_i;
      default: add_cin = ~carry_i;
    endcase
  end

  alu8_adder #(.DATA_W(DATA_W)) u_add (
    .x_i      (acc_i),
    .y_i      (add_y),
    .cin_i    (add_cin),
    .sum_o    (add_sum),
    .half_c_o (add_half_c),
    .cout_o   (add_cout)
  );

  always_comb begin
    case (ctrl.rsel)
      RS_ADD:  res = add_sum;
      RS_AND:  res = acc_i & opnd_i;
      RS_OR:   res = acc_i | opnd_i;
      RS_XOR:  res = acc_i ^ opnd_i;
      RS_CMA:  res = ~acc_i;
      RS_RLC:  res = {acc_i[MSB-1:0], acc_i[MSB]};
      RS_RRC:  res = {acc_i[0], acc_i[MSB:1]};
      RS_RAL:  res = {acc_i[MSB-1:0], carry_i};
      RS_RAR:  res = {carry_i, acc_i[MSB:1]};
      default: res = acc_i;
    endcase
  end

  alu8_parity #(.DATA_W(DATA_W)) u_par (
    .d_i    (res),
    .even_o (par_even)
  );

  always_comb begin
    ac_n = ctrl.ac_from_add & add_half_c;
    case (ctrl.cysel)
      CY_COUT:  cy_n = add_cout;
      CY_NCOUT: cy_n = ~add_cout;
      CY_ZERO:  cy_n = 1'b0;
      CY_MSB:   cy_n = acc_i[MSB];
      CY_LSB:   cy_n = acc_i[0];
      CY_NCIN:  cy_n = ~carry_i;
      default:  cy_n = 1'b1;
    endcase
  end

  alu8_flagreg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (flag_we_i),
    .upd_szp_i (ctrl.upd_szp),
    .upd_ac_i  (ctrl.upd_ac),
    .upd_cy_i  (ctrl.upd_cy),
    .s_i       (res[MSB]),
    .z_i       (res == '0),
    .ac_i      (ac_n),
    .p_i       (par_even),
    .cy_i      (cy_n),
    .flags_o   (flags_o)
  );

  assign result_o    = res;
  assign result_we_o = ctrl.wr_acc;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_i,
  input logic              carry_i,
  input logic              flag_we_i,
  input logic [7:0]        result_o,
  input logic              result_we_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic szp_op;
  assign szp_op = (op_i <= OP_CMP) || (op_i == OP_INC) || (op_i == OP_DEC);

  assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && szp_op |=> flags_o[FB_S] == $past(result_o[7]));

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && szp_op |=> flags_o[FB_Z] == ($past(result_o) == 8'h00));

  assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && szp_op |=> flags_o[FB_P] == ~(^$past(result_o)));

  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_CMP |-> !result_we_o);

  assert_cma_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_CMA |=> $stable(flags_o));

  assert_stc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_STC |=> flags_o[FB_CY]);

  assert_cmc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && op_i == OP_CMC |=> flags_o[FB_CY] == !$past(carry_i));

  assert_incdec_cy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i && (op_i == OP_INC || op_i == OP_DEC) |=> $stable(flags_o[FB_CY]));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_o));

  assert_unused_R14: assert property (@(posedge clk) disable iff (!rst_n)
    op_i > OP_DEC |-> !result_we_o);
endmodule

bind alu8_flagged alu8_flagged_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .carry_i     (carry_i),
  .flag_we_i   (flag_we_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .flags_o     (flags_o)
);

// File: tb/tb_alu8_flagged.sv
`timescale 1ns/1ps
module tb_alu8_flagged;
  logic       clk;
  logic       rst_n;
  logic [7:0] acc_i, opnd_i;
  logic [4:0] op_i;
  logic       carry_i, flag_we_i;
  logic [7:0] result_o;
  logic       result_we_o;
  logic [7:0] flags_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] prev_flags;

  alu8_flagged dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
    .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .result_we_o(result_we_o), .flags_o(flags_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req[4], op[5], acc[8], opnd[8], cin, res[8], we, flag_mask[8], flag_val[8]}
  localparam int NV = 23;
  localparam logic [50:0] TBL [0:NV-1] = '{
    {4'd1,  5'd0,  8'h3A, 8'h2C, 1'b0, 8'h66, 1'b1, 8'hD5, 8'h14}, // R1
    {4'd1,  5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 8'hD5, 8'h55}, // R1
    {4'd1,  5'd0,  8'h01, 8'h01, 1'b1, 8'h02, 1'b1, 8'hD5, 8'h00}, // R1
    {4'd4,  5'd1,  8'h7F, 8'h00, 1'b1, 8'h80, 1'b1, 8'hD5, 8'h90}, // R4
    {4'd3,  5'd2,  8'h10, 8'h01, 1'b0, 8'h0F, 1'b1, 8'hD5, 8'h04}, // R3
    {4'd2,  5'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 1'b1, 8'hD5, 8'h81}, // R2
    {4'd2,  5'd3,  8'h20, 8'h10, 1'b1, 8'h0F, 1'b1, 8'hD5, 8'h04}, // R2
    {4'd5,  5'd7,  8'h42, 8'h42, 1'b0, 8'h00, 1'b0, 8'hD5, 8'h54}, // R5
    {4'd6,  5'd4,  8'hF0, 8'h3C, 1'b0, 8'h30, 1'b1, 8'hD5, 8'h04}, // R6
    {4'd6,  5'd5,  8'h81, 8'h02, 1'b0, 8'h83, 1'b1, 8'hD5, 8'h80}, // R6
    {4'd6,  5'd6,  8'h5A, 8'h5A, 1'b0, 8'h00, 1'b1, 8'hD5, 8'h44}, // R6
    {4'd7,  5'd8,  8'h35, 8'h00, 1'b0, 8'hCA, 1'b1, 8'h00, 8'h00}, // R7
    {4'd8,  5'd9,  8'h81, 8'h00, 1'b0, 8'h03, 1'b1, 8'h01, 8'h01}, // R8
    {4'd8,  5'd10, 8'h02, 8'h00, 1'b1, 8'h01, 1'b1, 8'h01, 8'h00}, // R8
    {4'd9,  5'd11, 8'h80, 8'h00, 1'b0, 8'h00, 1'b1, 8'h01, 8'h01}, // R9
    {4'd9,  5'd12, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 8'h01, 8'h01}, // R9
    {4'd10, 5'd13, 8'h11, 8'h00, 1'b1, 8'h11, 1'b0, 8'h01, 8'h00}, // R10
    {4'd10, 5'd14, 8'h22, 8'h00, 1'b0, 8'h22, 1'b0, 8'h01, 8'h01}, // R10
    {4'd11, 5'd15, 8'h0F, 8'h00, 1'b0, 8'h10, 1'b1, 8'hD4, 8'h10}, // R11
    {4'd11, 5'd15, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 8'hD4, 8'h54}, // R11
    {4'd11, 5'd16, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 8'hD4, 8'h84}, // R11
    {4'd3,  5'd16, 8'h01, 8'h00, 1'b0, 8'h00, 1'b1, 8'hD4, 8'h54}, // R3
    {4'd14, 5'd20, 8'h77, 8'h00, 1'b1, 8'h77, 1'b0, 8'h00, 8'h00}  // R14
  };

  task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_i = '0; opnd_i = '0; op_i = '0; carry_i = 1'b0; flag_we_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(12, "reset flag byte", flags_o, 8'h02); // R12
    rst_n = 1'b1;
    prev_flags = 8'h02;

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      logic [7:0]  expf;
      int          rq;
      v = TBL[i];
      rq = int'(v[50:47]);
      @(negedge clk);
      op_i = v[46:42]; acc_i = v[41:34]; opnd_i = v[33:26]; carry_i = v[25];
      flag_we_i = 1'b1;
      #1;
      chk(rq, "result", result_o, v[24:17]);
      chk(rq, "result_we", {7'd0, result_we_o}, {7'd0, v[16]});
      expf = (prev_flags & ~v[15:8]) | v[7:0];
      @(negedge clk);
      flag_we_i = 1'b0;
      chk(rq, "flags", flags_o, expf);
      prev_flags = expf;
    end

    // R13: writes disabled, an op that would change every flag
    op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'h01; carry_i = 1'b0; flag_we_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(13, "flags held", flags_o, prev_flags);
    op_i = 5'd13; carry_i = 1'b0;
    @(negedge clk);
    chk(13, "flags held cmc", flags_o, prev_flags);

    // R12: layout of set flags, then asynchronous reset mid-cycle
    op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'h01; flag_we_i = 1'b1;
    @(negedge clk);
    flag_we_i = 1'b0;
    chk(12, "layout Z AC P CY", flags_o, 8'h57);
    #1 rst_n = 1'b0;
    #1;
    chk(12, "async reset value", flags_o, 8'h02);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(12, "after reset release", flags_o, 8'h02);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule